// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a device virtual address into a physical address by walking a two-level table held in memory. A requester presents an address, a read/write flag and a requester bus ID. The block then reads one word from the top-level directory, whose base comes from the `dir_base` input. If that word marks a present second-level table, it reads one word from that table. The leaf word it reads supplies the physical page number and the access rights. The block returns either the physical address with the leaf's attribute bits, or a fault.

Pages are 4 KB. The virtual address splits into a 10-bit directory index (bits 31:22), a 10-bit table index (bits 21:12) and a 12-bit page offset. A fault report carries three things: the faulting virtual address, a status word holding the direction and the bus ID, and a cause that separates a translation or permission fault from a bus error returned by the memory. The block holds a single-entry result cache. A repeated access to the last successfully translated page therefore completes without any memory reads. A flush input empties that cache after software edits the tables.

The block serves one request at a time. It raises `req_ready` only while idle.

Top module: `pgwalk_top`

## Requirements
- R1: After reset, `req_ready` is 1, and `rsp_valid`, `flt_valid` and `mem_rd_req` are all 0.
- R2: On a cache miss, the first memory read goes to `{dir_base[31:12], va[31:22], 2'b00}`. The second read goes to `{E1[31:12], va[21:12], 2'b00}`, where E1 is the directory word, so bits 11:0 of E1 are ignored. `mem_rd_req` and `mem_rd_addr` stay unchanged until `mem_rd_done`.
- R3: On success, `rsp_paddr` equals `{leaf[31:12], va[11:0]}` and `rsp_attr` equals `leaf[8:3]`, passed through unchanged.
- R4: If the directory word has bit 0 (present) clear, the block reports a page fault after exactly one memory read.
- R5: If the leaf word has bit 0 (present) clear, the block reports a page fault.
- R6: A read needs leaf bit 1 set and a write needs leaf bit 2 set. Without the needed bit, the access is a page fault.
- R7: `mem_rd_err` on either read ends the walk with a bus error. That read is the last one made.
- R8: A fault gives `rsp_valid=1`, `rsp_fault=1` and `flt_valid=1`. `flt_cause` is 2'b01 for a page fault and 2'b10 for a bus error. `flt_vaddr` is the request address. `flt_status` has bit 5 equal to the write flag, bits 10:6 equal to the bus ID, and bits 4:0 equal to 0. `rsp_paddr` and `rsp_attr` are 0.
- R9: `req_ready` is low from the cycle after acceptance until the cycle after the one-cycle `rsp_valid` pulse. No memory read is issued while the block is idle.
- R10: A request whose `dir_base[31:12]` and `va[31:12]` match the last successful translation is answered from the cached leaf with no memory read. `rsp_valid` is seen two clock edges after acceptance, and the read and write rights are checked again against the cached leaf.
- R11: A faulting walk never fills the cache. A pulse on `cache_flush`, or a different `dir_base`, forces a new walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and accepting |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| req_bus_id | input | 5 | Requester bus ID |
| dir_base | input | 32 | Directory base, sampled at acceptance; bits 11:0 ignored |
| cache_flush | input | 1 | Empties the result cache |
| mem_rd_req | output | 1 | Memory word read request, held until done |
| mem_rd_addr | output | 32 | Byte address of the word being read |
| mem_rd_done | input | 1 | Read data or error valid this cycle |
| mem_rd_data | input | 32 | Read data word |
| mem_rd_err | input | 1 | Read returned a bus error |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_fault | output | 1 | Result is a fault |
| rsp_paddr | output | 32 | Physical address, 0 on a fault |
| rsp_attr | output | 6 | Leaf attribute bits 8:3, 0 on a fault |
| flt_valid | output | 1 | Fault report valid |
| flt_cause | output | 2 | 01 page fault, 10 bus error |
| flt_vaddr | output | 32 | Faulting virtual address |
| flt_status | output | 11 | Bit 5 write, bits 10:6 bus ID |

## Verification
The walk is exercised against a table image that contains mapped pages with every combination of read and write rights, a missing second-level table, a missing leaf, and bus errors at each level. Each case is tried with several memory latencies. These patterns tell apart the walk that stops after the directory read from the walk that stops after the leaf read, and a rights fault from a presence fault. Repeated accesses to the same page, issued after the leaf word has been changed in memory, show whether an answer came from the cache. Flushes, faulting pages and a switch to a second directory base then show that each of these forces a new walk.

// File: rtl/pgwalk_pkg.sv
// Shared constants and types for the page table walker.
// Assumes 4-byte table entries whose flag bits sit at fixed low positions.
package pgwalk_pkg;
    localparam int PRESENT_BIT  = 0;
    localparam int READ_BIT     = 1;
    localparam int WRITE_BIT    = 2;
    localparam int ATTR_LO      = 3;
    localparam int ATTR_HI      = 8;
    localparam int ATTR_W       = ATTR_HI - ATTR_LO + 1;
    localparam int ST_WRITE_BIT = 5;
    localparam int ST_ID_LO     = 6;

    localparam logic [1:0] CAUSE_NONE = 2'b00;
    localparam logic [1:0] CAUSE_PAGE = 2'b01;
    localparam logic [1:0] CAUSE_BUS  = 2'b10;

    typedef enum logic [2:0] {
        W_IDLE,
        W_LOOK,
        W_DIR,
        W_LEAF,
        W_DONE
    } walk_state_e;
endpackage

// File: rtl/pgwalk_addr.sv
// Forms the byte addresses of the directory word and of the leaf word.
// Assumes each table is one page: 2^IDX_W entries of 4 bytes each.
module pgwalk_addr #(
    parameter int IDX_W = 10,
    localparam int OFF_W = IDX_W + 2,
    localparam int AW    = 3 * IDX_W + 2,
    localparam int PN_W  = AW - OFF_W
) (
    input  logic [PN_W-1:0] base_pn,
    input  logic [PN_W-1:0] tbl_pn,
    input  logic [AW-1:0]   vaddr,
    output logic [AW-1:0]   dir_addr,
    output logic [AW-1:0]   leaf_addr
);
    // Concatenate each page number with the matching index, scaled by the entry size.
    always_comb begin
        dir_addr  = {base_pn, vaddr[AW-1 -: IDX_W], 2'b00};
        leaf_addr = {tbl_pn, vaddr[OFF_W+IDX_W-1:OFF_W], 2'b00};
    end
endmodule

// File: rtl/pgwalk_perm.sv
// Decodes one table word: present flag, access rights for the current direction, attributes.
// Assumes the caller selects which word (cached leaf or fresh read data) is examined.
module pgwalk_perm #(
    parameter int AW = 32
) (
    input  logic                       write,
    input  logic [AW-1:0]              entry,
    output logic                       present,
    output logic                       allowed,
    output logic [pgwalk_pkg::ATTR_W-1:0] attr
);
    import pgwalk_pkg::*;

    // Present bit, plus the right that matches the access direction.
    always_comb begin
        present = entry[PRESENT_BIT];
        allowed = entry[PRESENT_BIT] & (write ? entry[WRITE_BIT] : entry[READ_BIT]);
        attr    = entry[ATTR_HI:ATTR_LO];
    end
endmodule

// File: rtl/pgwalk_tcache.sv
// Single-entry cache of the last successful leaf, tagged by directory page and virtual page.
// Assumes flush has priority over a fill in the same cycle; EN=0 builds no storage.
module pgwalk_tcache #(
    parameter int  AW    = 32,
    parameter int  TAG_W = 40,
    parameter bit  EN    = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             fill,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic [AW-1:0]    fill_leaf,
    input  logic [TAG_W-1:0] look_tag,
    output logic             hit,
    output logic [AW-1:0]    hit_leaf
);
    generate
        if (EN) begin : g_store
            logic             vld_q;
            logic [TAG_W-1:0] tag_q;
            logic [AW-1:0]    leaf_q;

            // Valid flag: cleared by reset or flush, set by a fill.
            always_ff @(posedge clk) begin
                if (!rst_n)     vld_q <= 1'b0;
                else if (flush) vld_q <= 1'b0;
                else if (fill)  vld_q <= 1'b1;
            end

            // Tag and leaf payload captured on a fill.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    tag_q  <= '0;
                    leaf_q <= '0;
                end else if (fill && !flush) begin
                    tag_q  <= fill_tag;
                    leaf_q <= fill_leaf;
                end
            end

            assign hit      = vld_q && (tag_q == look_tag);
            assign hit_leaf = leaf_q;
        end else begin : g_none
            logic unused_in;
            assign unused_in = ^{clk, rst_n, flush, fill, fill_tag, fill_leaf, look_tag};
            assign hit       = 1'b0;
            assign hit_leaf  = '0;
        end
    endgenerate
endmodule

// File: rtl/pgwalk_top.sv
// Two-level page table walker: one request at a time, a directory read then a leaf read,
// with a single-entry result cache in front. Assumes the memory port holds at most one
// read in flight and answers it with a one-cycle done strobe.
module pgwalk_top #(
    parameter int  IDX_W    = 10,
    parameter int  ID_W     = 5,
    parameter bit  CACHE_EN = 1'b1,
    localparam int AW       = 3 * IDX_W + 2,
    localparam int OFF_W    = IDX_W + 2,
    localparam int ST_W     = pgwalk_pkg::ST_ID_LO + ID_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic [AW-1:0]                 req_vaddr,
    input  logic                          req_write,
    input  logic [ID_W-1:0]               req_bus_id,
    input  logic [AW-1:0]                 dir_base,
    input  logic                          cache_flush,
    output logic                          mem_rd_req,
    output logic [AW-1:0]                 mem_rd_addr,
    input  logic                          mem_rd_done,
    input  logic [AW-1:0]                 mem_rd_data,
    input  logic                          mem_rd_err,
    output logic                          rsp_valid,
    output logic                          rsp_fault,
    output logic [AW-1:0]                 rsp_paddr,
    output logic [pgwalk_pkg::ATTR_W-1:0] rsp_attr,
    output logic                          flt_valid,
    output logic [1:0]                    flt_cause,
    output logic [AW-1:0]                 flt_vaddr,
    output logic [ST_W-1:0]               flt_status
);
    import pgwalk_pkg::*;

    localparam int PN_W  = AW - OFF_W;
    localparam int TAG_W = 2 * PN_W;

    walk_state_e        st_q, st_d;
    logic [AW-1:0]      va_q;
    logic [PN_W-1:0]    base_q;
    logic [PN_W-1:0]    tbl_q;
    logic               wr_q;
    logic [ID_W-1:0]    id_q;

    logic [AW-1:0]      dir_addr, leaf_addr;
    logic [AW-1:0]      leaf_sel;
    logic               ent_present, ent_allowed;
    logic [ATTR_W-1:0]  ent_attr;
    logic               hit;
    logic [AW-1:0]      hit_leaf;
    logic [TAG_W-1:0]   look_tag;
    logic               fill;

    logic               fin;
    logic [1:0]         fin_cause;
    logic [1:0]         cause_q;
    logic [AW-1:0]      paddr_q;
    logic [ATTR_W-1:0]  attr_q;
    logic               unused_bits;

    assign unused_bits = ^mem_rd_data[OFF_W-1:ATTR_HI+1];

    pgwalk_addr #(.IDX_W(IDX_W)) u_addr (
        .base_pn   (base_q),
        .tbl_pn    (tbl_q),
        .vaddr     (va_q),
        .dir_addr  (dir_addr),
        .leaf_addr (leaf_addr)
    );

    // The cached leaf is examined during lookup; otherwise the word coming back from memory.
    assign leaf_sel = (st_q == W_LOOK) ? hit_leaf : mem_rd_data;

    pgwalk_perm #(.AW(AW)) u_perm (
        .write   (wr_q),
        .entry   (leaf_sel),
        .present (ent_present),
        .allowed (ent_allowed),
        .attr    (ent_attr)
    );

    assign look_tag = {base_q, va_q[AW-1:OFF_W]};
    assign fill     = (st_q == W_LEAF) && mem_rd_done && !mem_rd_err && ent_allowed;

    pgwalk_tcache #(.AW(AW), .TAG_W(TAG_W), .EN(CACHE_EN)) u_cache (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (cache_flush),
        .fill      (fill),
        .fill_tag  (look_tag),
        .fill_leaf (mem_rd_data),
        .look_tag  (look_tag),
        .hit       (hit),
        .hit_leaf  (hit_leaf)
    );

    // Next state and the end-of-walk decision with its cause.
    always_comb begin
        st_d      = st_q;
        fin       = 1'b0;
        fin_cause = CAUSE_NONE;
        case (st_q)
            W_IDLE: if (req_valid) st_d = W_LOOK;
            W_LOOK: begin
                if (hit) begin
                    fin       = 1'b1;
                    fin_cause = ent_allowed ? CAUSE_NONE : CAUSE_PAGE;
                end else begin
                    st_d = W_DIR;
                end
            end
            W_DIR: begin
                if (mem_rd_done) begin
                    if (mem_rd_err) begin
                        fin       = 1'b1;
                        fin_cause = CAUSE_BUS;
                    end else if (!ent_present) begin
                        fin       = 1'b1;
                        fin_cause = CAUSE_PAGE;
                    end else begin
                        st_d = W_LEAF;
                    end
                end
            end
            W_LEAF: begin
                if (mem_rd_done) begin
                    fin = 1'b1;
                    if (mem_rd_err)        fin_cause = CAUSE_BUS;
                    else if (!ent_allowed) fin_cause = CAUSE_PAGE;
                    else                   fin_cause = CAUSE_NONE;
                end
            end
            W_DONE:  st_d = W_IDLE;
            default: st_d = W_IDLE;
        endcase
        if (fin) st_d = W_DONE;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= W_IDLE;
        else        st_q <= st_d;
    end

    // Request capture at acceptance; held for the whole walk and the fault report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q   <= '0;
            base_q <= '0;
            wr_q   <= 1'b0;
            id_q   <= '0;
        end else if (st_q == W_IDLE && req_valid) begin
            va_q   <= req_vaddr;
            base_q <= dir_base[AW-1:OFF_W];
            wr_q   <= req_write;
            id_q   <= req_bus_id;
        end
    end

    // Second-level table page number, taken from a present directory word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tbl_q <= '0;
        else if (st_q == W_DIR && mem_rd_done && !mem_rd_err)
            tbl_q <= mem_rd_data[AW-1:OFF_W];
    end

    // Result registers: address and attributes on success, zeros on a fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q <= CAUSE_NONE;
            paddr_q <= '0;
            attr_q  <= '0;
        end else if (fin) begin
            cause_q <= fin_cause;
            if (fin_cause == CAUSE_NONE) begin
                paddr_q <= {leaf_sel[AW-1:OFF_W], va_q[OFF_W-1:0]};
                attr_q  <= ent_attr;
            end else begin
                paddr_q <= '0;
                attr_q  <= '0;
            end
        end
    end

    assign req_ready   = (st_q == W_IDLE);
    assign mem_rd_req  = (st_q == W_DIR) || (st_q == W_LEAF);
    assign mem_rd_addr = (st_q == W_LEAF) ? leaf_addr : dir_addr;
    assign rsp_valid   = (st_q == W_DONE);
    assign rsp_fault   = (cause_q != CAUSE_NONE);
    assign rsp_paddr   = paddr_q;
    assign rsp_attr    = attr_q;
    assign flt_valid   = rsp_valid && rsp_fault;
    assign flt_cause   = cause_q;
    assign flt_vaddr   = va_q;
    assign flt_status  = {id_q, wr_q, {ST_WRITE_BIT{1'b0}}};
endmodule

// File: rtl/pgwalk_sva.sv
// Property checker for the walker, attached to every pgwalk_top instance by bind.
// Keeps its own copy of the accepted address to check the page offset of each result.
module pgwalk_sva #(
    parameter int  IDX_W = 10,
    parameter int  ID_W  = 5,
    localparam int AW    = 3 * IDX_W + 2,
    localparam int OFF_W = IDX_W + 2,
    localparam int ST_W  = pgwalk_pkg::ST_ID_LO + ID_W
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          req_valid,
    input logic                          req_ready,
    input logic [AW-1:0]                 req_vaddr,
    input logic                          mem_rd_req,
    input logic [AW-1:0]                 mem_rd_addr,
    input logic                          mem_rd_done,
    input logic                          rsp_valid,
    input logic                          rsp_fault,
    input logic [AW-1:0]                 rsp_paddr,
    input logic                          flt_valid,
    input logic [1:0]                    flt_cause,
    input logic [ST_W-1:0]               flt_status
);
    logic [OFF_W-1:0] seen_off;

    // Page offset of the most recently accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n)                      seen_off <= '0;
        else if (req_valid && req_ready) seen_off <= req_vaddr[OFF_W-1:0];
    end

    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (req_ready && !rsp_valid && !mem_rd_req));

    a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

    a_r9_no_read_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_rd_req && !rsp_valid));

    a_r2_read_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_done) |=> (mem_rd_req && $stable(mem_rd_addr)));

    a_r2_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> (mem_rd_addr[1:0] == 2'b00));

    a_r8_one_cause: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid |-> ($countones(flt_cause) == 1));

    a_r8_status_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid |-> (flt_status[pgwalk_pkg::ST_WRITE_BIT-1:0] == '0));

    a_r8_fault_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));

    a_r3_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_paddr[OFF_W-1:0] == seen_off));
endmodule

bind pgwalk_top pgwalk_sva #(.IDX_W(IDX_W), .ID_W(ID_W)) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_vaddr   (req_vaddr),
    .mem_rd_req  (mem_rd_req),
    .mem_rd_addr (mem_rd_addr),
    .mem_rd_done (mem_rd_done),
    .rsp_valid   (rsp_valid),
    .rsp_fault   (rsp_fault),
    .rsp_paddr   (rsp_paddr),
    .flt_valid   (flt_valid),
    .flt_cause   (flt_cause),
    .flt_status  (flt_status)
);

// File: tb/sim_pgwalk_top.sv
// Bench for pgwalk_top: a behavioural table image and memory responder, a reference walk
// with its own one-entry cache model, and per-request comparison of every output.
module sim_pgwalk_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic [4:0]  req_bus_id = '0;
    logic [31:0] dir_base = '0;
    logic        cache_flush = 1'b0;
    logic        mem_rd_req;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_done = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic        mem_rd_err = 1'b0;
    logic        rsp_valid, rsp_fault, flt_valid;
    logic [31:0] rsp_paddr, flt_vaddr;
    logic [5:0]  rsp_attr;
    logic [1:0]  flt_cause;
    logic [10:0] flt_status;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    int lat = 0;
    int wcnt = 0;

    logic [31:0] mem [logic [31:0]];
    bit          errm [logic [31:0]];
    logic [31:0] seen_q [$];

    bit          m_valid = 1'b0;
    logic [39:0] m_tag = '0;
    logic [31:0] m_leaf = '0;

    localparam logic [31:0] B0 = 32'h0010_0000;
    localparam logic [31:0] B1 = 32'h0030_0000;
    localparam logic [31:0] T1 = 32'h0020_0000;

    pgwalk_top u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_bus_id(req_bus_id), .dir_base(dir_base),
        .cache_flush(cache_flush),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_done(mem_rd_done),
        .mem_rd_data(mem_rd_data), .mem_rd_err(mem_rd_err),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
        .rsp_attr(rsp_attr), .flt_valid(flt_valid), .flt_cause(flt_cause),
        .flt_vaddr(flt_vaddr), .flt_status(flt_status)
    );

    always #5 clk = ~clk;

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Watchdog: a hung run is one failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            failures++;
            $display("FAIL watchdog act=%0d exp=<100000", cycles);
            summary();
        end
    end

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    // Memory responder: answers a held read after lat cycles, one-cycle done.
    always @(negedge clk) begin
        if (mem_rd_done) begin
            mem_rd_done = 1'b0;
            mem_rd_err  = 1'b0;
        end else if (mem_rd_req) begin
            if (wcnt >= lat) begin
                mem_rd_done = 1'b1;
                mem_rd_data = rd(mem_rd_addr);
                mem_rd_err  = errm.exists(mem_rd_addr);
                seen_q.push_back(mem_rd_addr);
                wcnt = 0;
            end else begin
                wcnt++;
            end
        end
    end

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", what, act, exp);
        end
    endtask

    task automatic flush();
        @(negedge clk);
        cache_flush = 1'b1;
        @(negedge clk);
        cache_flush = 1'b0;
        m_valid = 1'b0;
    endtask

    // One translation: reference walk, drive, wait, compare.
    task automatic xlate(input logic [31:0] va, input bit wr, input logic [4:0] id, input string rq);
        logic [31:0] e1, leaf, a1, a2, exp_pa;
        logic [1:0]  cause;
        logic [5:0]  exp_at;
        int          nrd;
        bit          hit, busy_ok;
        int          n;
        leaf = '0; a1 = '0; a2 = '0; e1 = '0; nrd = 0;
        hit = m_valid && (m_tag == {dir_base[31:12], va[31:12]});
        if (hit) begin
            leaf  = m_leaf;
            cause = (wr ? leaf[2] : leaf[1]) && leaf[0] ? 2'b00 : 2'b01;
        end else begin
            a1  = {dir_base[31:12], va[31:22], 2'b00};
            nrd = 1;
            if (errm.exists(a1)) cause = 2'b10;
            else begin
                e1 = rd(a1);
                if (!e1[0]) cause = 2'b01;
                else begin
                    a2  = {e1[31:12], va[21:12], 2'b00};
                    nrd = 2;
                    if (errm.exists(a2)) cause = 2'b10;
                    else begin
                        leaf  = rd(a2);
                        cause = (leaf[0] && (wr ? leaf[2] : leaf[1])) ? 2'b00 : 2'b01;
                        if (cause == 2'b00) begin
                            m_valid = 1'b1;
                            m_tag   = {dir_base[31:12], va[31:12]};
                            m_leaf  = leaf;
                        end
                    end
                end
            end
        end
        exp_pa = (cause == 2'b00) ? {leaf[31:12], va[11:0]} : 32'h0;
        exp_at = (cause == 2'b00) ? leaf[8:3] : 6'h0;

        @(negedge clk);
        chk(req_ready, {rq, " R9 ready before request"}, req_ready, 1);
        seen_q.delete();
        req_valid = 1'b1; req_vaddr = va; req_write = wr; req_bus_id = id;
        @(negedge clk);
        req_valid = 1'b0;
        n = 1;
        busy_ok = 1'b1;
        while (!rsp_valid && n < 80) begin
            if (req_ready) busy_ok = 1'b0;
            @(negedge clk);
            n++;
        end
        if (req_ready) busy_ok = 1'b0;
        chk(rsp_valid, {rq, " response arrives"}, rsp_valid, 1);
        chk(busy_ok, {rq, " R9 ready low while busy"}, busy_ok, 1);
        chk(rsp_fault == (cause != 2'b00), {rq, " rsp_fault"}, rsp_fault, cause != 2'b00);
        chk(rsp_paddr == exp_pa, {rq, " R3 paddr"}, rsp_paddr, exp_pa);
        chk(rsp_attr == exp_at, {rq, " R3 attr"}, rsp_attr, exp_at);
        chk(flt_valid == (cause != 2'b00), {rq, " R8 flt_valid"}, flt_valid, cause != 2'b00);
        if (cause != 2'b00) begin
            chk(flt_cause == cause, {rq, " R8 cause"}, flt_cause, cause);
            chk(flt_vaddr == va, {rq, " R8 vaddr"}, flt_vaddr, va);
            chk(flt_status == {id, wr, 5'b0}, {rq, " R8 status"}, flt_status, {id, wr, 5'b0});
        end
        chk(seen_q.size() == nrd, {rq, " read count"}, seen_q.size(), nrd);
        if (nrd >= 1 && seen_q.size() >= 1)
            chk(seen_q[0] == a1, {rq, " R2 directory address"}, seen_q[0], a1);
        if (nrd == 2 && seen_q.size() == 2)
            chk(seen_q[1] == a2, {rq, " R2 leaf address"}, seen_q[1], a2);
        if (hit) chk(n == 2, {rq, " R10 hit latency"}, n, 2);
        @(negedge clk);
        chk(req_ready && !rsp_valid, {rq, " R9 ready after pulse"}, {req_ready, rsp_valid}, 2'b10);
    endtask

    initial begin
        // Table image under B0; the directory word carries junk in bits 11:1.
        mem[B0 + 32'd4]  = T1 | 32'h0000_0F01;
        mem[T1 + 32'd4]  = 32'hABCD_E157;       // rw, attr 0x2A
        mem[T1 + 32'd8]  = 32'h1234_5003;       // read only
        mem[T1 + 32'd12] = 32'h5555_5005;       // write only
        mem[T1 + 32'd16] = 32'h6666_6006;       // leaf not present
        errm[T1 + 32'd20] = 1'b1;               // leaf read errors
        errm[B0 + 32'd24] = 1'b1;               // directory read errors
        mem[B1 + 32'd4]  = 32'h0050_0001;
        mem[32'h0050_0004] = 32'h7777_7003;
        dir_base = B0;

        repeat (3) @(negedge clk);
        chk(req_ready && !rsp_valid && !flt_valid && !mem_rd_req, "R1 reset state",
            {req_ready, rsp_valid, flt_valid, mem_rd_req}, 4'b1000);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !rsp_valid && !mem_rd_req, "R1 after release",
            {req_ready, rsp_valid, mem_rd_req}, 3'b100);

        lat = 1;
        xlate(32'h0040_1234, 1'b0, 5'd3,  "R3 walk read");
        lat = 0;
        xlate(32'h0040_1ABC, 1'b1, 5'd7,  "R10 hit write");
        mem[T1 + 32'd4] = 32'h9999_9007;
        xlate(32'h0040_1000, 1'b0, 5'd1,  "R10 hit stale leaf");
        flush();
        xlate(32'h0040_1FFF, 1'b0, 5'd1,  "R11 after flush");
        lat = 3;
        xlate(32'h0040_2010, 1'b1, 5'h1F, "R6 write to read-only");
        xlate(32'h0040_2010, 1'b0, 5'd2,  "R6 read of read-only");
        xlate(32'h0040_2020, 1'b1, 5'd9,  "R10 rights on hit");
        lat = 0;
        xlate(32'h0040_3000, 1'b0, 5'd4,  "R6 read of write-only");
        xlate(32'h0040_3004, 1'b1, 5'd4,  "R6 write of write-only");
        xlate(32'h0140_0000, 1'b1, 5'h15, "R4 directory absent");
        xlate(32'h0040_4000, 1'b0, 5'd6,  "R5 leaf absent");
        lat = 2;
        xlate(32'h0180_0123, 1'b0, 5'd8,  "R7 directory bus error");
        xlate(32'h0040_5000, 1'b1, 5'd10, "R7 leaf bus error");
        xlate(32'h0040_4000, 1'b0, 5'd6,  "R11 fault not cached");
        lat = 1;
        xlate(32'h0040_1000, 1'b0, 5'd0,  "R11 fill before base change");
        dir_base = B1;
        xlate(32'h0040_1000, 1'b0, 5'd0,  "R11 new directory base");
        summary();
    end
endmodule